// File: doc/BRIEF.md
# Double-swap round key sequencer

This block turns a 128-bit cipher key and its precomputed 128-bit intermediate key into the stream of 32-bit round keys used by a four-branch Feistel data path. A pulse on `start_i` while the block is idle loads both values. The key is presented as four whitening words, which stay stable until the next load. The block then walks through a fixed number of steps. Each step yields four round keys, and the round keys leave the block as 64-bit pairs under a valid/ready handshake.

In each step the block takes the intermediate key register and mixes in four 32-bit constants. It also mixes in the original key on odd steps. The block requests the four constants through a step index output and expects them on an input port in the same cycle. After both pairs of a step have been accepted, the intermediate key register is rewritten by a fixed 128-bit double-swap permutation, so the permutation is applied once every two rounds. The final pair carries a last flag. After it is accepted the block returns to idle and can be loaded again.

Top module: `rk_seq`

## Requirements
- R1: After reset, `rk_valid_o`, `rk_last_o` and `con_idx_o` are 0 and `wk_o` is all zeros.
- R2: A `start_i` pulse while idle captures `key_i` into `wk_o`, with `wk_o[127:96]` as the first whitening key and `wk_o[31:0]` as the fourth. One cycle later `rk_valid_o` is 1 and `con_idx_o` is 0.
- R3: The double-swap unit `rks_dswap` maps X to Y, numbering bits from 0 at the MSB. Y bits 0..56 take X bits 7..63. Y bits 57..63 take X bits 121..127. Y bits 64..70 take X bits 0..6. Y bits 71..127 take X bits 64..120.
- R4: In step s, T = L xor `con_i`, and T is also xored with the loaded key when s is odd. The first pair of the step is T[127:64] and the second pair is T[63:0]. Within a pair, bits 63:32 hold the lower-numbered round key.
- R5: L starts as the loaded `lkey_i` value. It is replaced by its double swap only when the second pair of a step is accepted.
- R6: With the default of 36 round keys the block emits exactly 18 pairs. `rk_last_o` is 1 only while the 18th pair is offered.
- R7: While `rk_valid_o` is 1 and `rk_ready_i` is 0, `rk_o`, `rk_last_o` and `con_idx_o` hold their values.
- R8: `start_i` has no effect while a stream is running: `wk_o` and the rest of the stream are unchanged.
- R9: `con_idx_o` equals the current step number and stays below the step count (NUM_RK/4).
- R10: The cycle after the last pair is accepted, `rk_valid_o` is 0. A new start is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load key and intermediate key, begin a stream (idle only) |
| key_i | input | 128 | Cipher key |
| lkey_i | input | 128 | Precomputed intermediate key |
| con_idx_o | output | 4 | Step index selecting the four constants |
| con_i | input | 128 | Four 32-bit constants for step `con_idx_o`, first constant in bits 127:96 |
| wk_o | output | 128 | Four whitening keys |
| rk_valid_o | output | 1 | Round key pair valid |
| rk_ready_i | input | 1 | Consumer accepts the pair |
| rk_o | output | 64 | Round key pair |
| rk_last_o | output | 1 | Final pair of the stream |

## Verification
The hold check assumes that `con_i` is a pure function of `con_idx_o`, so it cannot change while a pair is stalled. The bench keeps within this assumption by computing `con_i` combinationally from the index with a fixed mixing function. The start checks assume that a load is only meaningful while idle. To exercise this, the stimulus pulses `start_i` with a different key partway through a stream and also changes `key_i` and `lkey_i` after each load. Ready is driven at random with several acceptance rates, so stalls fall on both halves of a step and on the last pair.

// File: rtl/rks_pkg.sv
package rks_pkg;
  localparam int unsigned BLK_W  = 128;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAIR_W = 2 * WORD_W;
  localparam int unsigned SWAP_S = 7;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [PAIR_W-1:0] pair_t;
endpackage

// File: rtl/rks_dswap.sv
module rks_dswap #(
  parameter int unsigned W = 128,
  parameter int unsigned S = 7
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned H = W / 2;

  // outer halves trade their S-bit end slices; middle segments move up/down
  assign y_o = {x_i[W-1-S:H], x_i[S-1:0], x_i[W-1:W-S], x_i[H-1:S]};
endmodule

// File: rtl/rks_ctrl.sv
module rks_ctrl #(
  parameter int unsigned NUM_STEPS = 9,
  localparam int unsigned STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ready_i,
  output logic              run_o,
  output logic              half_o,
  output logic [STEP_W-1:0] step_o,
  output logic              last_o,
  output logic              load_o,
  output logic              adv_o
);
  logic              run_q, half_q;
  logic [STEP_W-1:0] step_q;
  logic              fire;

  assign fire   = run_q && ready_i;
  assign load_o = start_i && !run_q;
  assign last_o = run_q && half_q && (step_q == STEP_W'(NUM_STEPS - 1));
  assign adv_o  = fire && half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      half_q <= 1'b0;
      step_q <= '0;
    end else if (load_o) begin
      run_q  <= 1'b1;
      half_q <= 1'b0;
      step_q <= '0;
    end else if (fire) begin
      half_q <= ~half_q;
      if (half_q) begin
        if (last_o) begin
          run_q  <= 1'b0;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign run_o  = run_q;
  assign half_o = half_q;
  assign step_o = step_q;
endmodule

// File: rtl/rks_datapath.sv
module rks_datapath
  import rks_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  adv_i,
  input  logic  odd_i,
  input  logic  half_i,
  input  blk_t  key_i,
  input  blk_t  lkey_i,
  input  blk_t  con_i,
  output blk_t  wk_o,
  output pair_t rk_o
);
  blk_t k_q, l_q, l_sw, t;

  rks_dswap #(.W(BLK_W), .S(SWAP_S)) u_dswap (
    .x_i (l_q),
    .y_o (l_sw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0;
      l_q <= '0;
    end else if (load_i) begin
      k_q <= key_i;
      l_q <= lkey_i;
    end else if (adv_i) begin
      l_q <= l_sw;
    end
  end

  always_comb begin
    t = l_q ^ con_i;
    if (odd_i) t = t ^ k_q;
  end

  assign rk_o = half_i ? t[PAIR_W-1:0] : t[BLK_W-1:PAIR_W];
  assign wk_o = k_q;
endmodule

// File: rtl/rk_seq.sv
module rk_seq
  import rks_pkg::*;
#(
  parameter int unsigned NUM_RK = 36,
  localparam int unsigned NUM_STEPS = NUM_RK / 4,
  localparam int unsigned STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [127:0]      key_i,
  input  logic [127:0]      lkey_i,
  output logic [STEP_W-1:0] con_idx_o,
  input  logic [127:0]      con_i,
  output logic [127:0]      wk_o,
  output logic              rk_valid_o,
  input  logic              rk_ready_i,
  output logic [63:0]       rk_o,
  output logic              rk_last_o
);
  logic              run, half, last, load, adv;
  logic [STEP_W-1:0] step;

  rks_ctrl #(.NUM_STEPS(NUM_STEPS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ready_i (rk_ready_i),
    .run_o   (run),
    .half_o  (half),
    .step_o  (step),
    .last_o  (last),
    .load_o  (load),
    .adv_o   (adv)
  );

  rks_datapath u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (adv),
    .odd_i  (step[0]),
    .half_i (half),
    .key_i  (key_i),
    .lkey_i (lkey_i),
    .con_i  (con_i),
    .wk_o   (wk_o),
    .rk_o   (rk_o)
  );

  assign con_idx_o  = step;
  assign rk_valid_o = run;
  assign rk_last_o  = last;
endmodule

// File: rtl/rk_seq_chk.sv
module rk_seq_chk #(
  parameter int unsigned NUM_RK = 36,
  localparam int unsigned NUM_STEPS = NUM_RK / 4,
  localparam int unsigned NUM_PAIRS = NUM_RK / 2,
  localparam int unsigned STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [127:0]      key_i,
  input logic [STEP_W-1:0] con_idx_o,
  input logic [127:0]      wk_o,
  input logic              rk_valid_o,
  input logic              rk_ready_i,
  input logic [63:0]       rk_o,
  input logic              rk_last_o
);
  logic [15:0] pair_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pair_cnt <= '0;
    else if (start_i && !rk_valid_o) pair_cnt <= '0;
    else if (rk_valid_o && rk_ready_i) pair_cnt <= pair_cnt + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!rk_valid_o && !rk_last_o);
    end
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !rk_valid_o |=> rk_valid_o && wk_o == $past(key_i) && con_idx_o == '0);

  p_last_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_last_o |-> rk_valid_o);

  p_last_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_valid_o && rk_ready_i && rk_last_o |-> pair_cnt == 16'(NUM_PAIRS - 1));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_valid_o && !rk_ready_i |=>
      rk_valid_o && $stable(rk_o) && $stable(rk_last_o) && $stable(con_idx_o));

  p_busy_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_valid_o && !(rk_ready_i && rk_last_o) |=> rk_valid_o && $stable(wk_o));

  p_idx_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    con_idx_o < STEP_W'(NUM_STEPS));

  p_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rk_valid_o && rk_ready_i && rk_last_o |=> !rk_valid_o);
endmodule

bind rk_seq rk_seq_chk #(.NUM_RK(NUM_RK)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .key_i      (key_i),
  .con_idx_o  (con_idx_o),
  .wk_o       (wk_o),
  .rk_valid_o (rk_valid_o),
  .rk_ready_i (rk_ready_i),
  .rk_o       (rk_o),
  .rk_last_o  (rk_last_o)
);

// File: tb/rk_seq_test.sv
`timescale 1ns/1ps
module rk_seq_test;
  import rks_pkg::*;

  localparam int NPAIR = 18;
  localparam int WD    = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  blk_t        key_i = '0, lkey_i = '0, con_i;
  logic [3:0]  con_idx_o;
  blk_t        wk_o;
  logic        rk_valid_o, rk_ready_i = 1'b0, rk_last_o;
  pair_t       rk_o;
  blk_t        sw_in = '0, sw_out;

  int n_chk = 0, n_fail = 0, cyc_total = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] con_word(input int n);
    logic [31:0] v;
    v = 32'(n) * 32'h9e37_79b9 + 32'h7f4a_7c15;
    return v ^ {v[18:0], v[31:19]};
  endfunction

  function automatic blk_t con_blk(input int s);
    return {con_word(4*s), con_word(4*s+1), con_word(4*s+2), con_word(4*s+3)};
  endfunction

  // bit-by-bit map in MSB-0 numbering
  function automatic blk_t dswap_model(input blk_t x);
    blk_t y;
    int src;
    for (int j = 0; j < 128; j++) begin
      if (j < 57)      src = j + 7;
      else if (j < 64) src = j + 64;
      else if (j < 71) src = j - 64;
      else             src = j - 7;
      y[127-j] = x[127-src];
    end
    return y;
  endfunction

  assign con_i = con_blk(int'(con_idx_o));

  rk_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i),
    .lkey_i(lkey_i), .con_idx_o(con_idx_o), .con_i(con_i), .wk_o(wk_o),
    .rk_valid_o(rk_valid_o), .rk_ready_i(rk_ready_i), .rk_o(rk_o),
    .rk_last_o(rk_last_o)
  );

  rks_dswap #(.W(128), .S(7)) u_sw (.x_i(sw_in), .y_o(sw_out));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string tag, input blk_t act, input blk_t exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WD) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: got %0d cycles expected < %0d", cyc_total, WD);
      summary();
      $finish;
    end
  end

  task automatic run_stream(input blk_t k, input blk_t l, input int rdy_pct, input bit poke);
    blk_t lcur = l;
    blk_t t, e;
    int pairs = 0, cyc = 0, s;
    bit rdy;
    @(negedge clk);
    key_i = k; lkey_i = l; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    key_i = {$urandom, $urandom, $urandom, $urandom};
    lkey_i = {$urandom, $urandom, $urandom, $urandom};
    check(wk_o == k, "R2 whitening load", wk_o, k);
    check(rk_valid_o && con_idx_o == 4'd0, "R2 valid after start",
          blk_t'({rk_valid_o, con_idx_o}), blk_t'(5'h10));
    while (pairs < NPAIR && cyc < 4000) begin
      s = pairs / 2;
      t = lcur ^ con_blk(s) ^ ((s % 2 == 1) ? k : '0);
      e = (pairs % 2 == 1) ? blk_t'(t[63:0]) : blk_t'(t[127:64]);
      check(rk_valid_o, "R6 valid until final pair", blk_t'(rk_valid_o), blk_t'(1));
      check(blk_t'(rk_o) == e, (s == 0) ? "R4 step mix" : "R5 swapped L stream",
            blk_t'(rk_o), e);
      check(int'(con_idx_o) == s, "R9 step index", blk_t'(con_idx_o), blk_t'(s));
      check(rk_last_o == (pairs == NPAIR-1), "R6 last flag",
            blk_t'(rk_last_o), blk_t'(pairs == NPAIR-1));
      check(wk_o == k, poke ? "R8 start ignored" : "R2 whitening hold", wk_o, k);
      if (poke && (cyc == 3 || cyc == 11)) begin
        start_i = 1'b1;
        key_i = ~k;
        lkey_i = ~l;
      end else begin
        start_i = 1'b0;
      end
      rdy = ($urandom_range(99) < rdy_pct);
      rk_ready_i = rdy;
      if (rdy) begin
        pairs++;
        if (pairs % 2 == 0) lcur = dswap_model(lcur);
      end
      @(negedge clk);
      cyc++;
    end
    rk_ready_i = 1'b0;
    start_i = 1'b0;
    check(!rk_valid_o && !rk_last_o, "R10 idle after last",
          blk_t'({rk_valid_o, rk_last_o}), '0);
  endtask

  initial begin
    blk_t x, y;
    void'($urandom(32'd2016));
    #12;
    check(!rk_valid_o && !rk_last_o && con_idx_o == 4'd0 && wk_o == '0, "R1 reset state",
          blk_t'({rk_valid_o, rk_last_o, con_idx_o}), '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R3 walking one, then random words
    for (int b = 0; b < 128; b++) begin
      x = blk_t'(1) << b;
      sw_in = x;
      #1;
      y = dswap_model(x);
      check(sw_out == y, "R3 double swap walking bit", sw_out, y);
    end
    for (int n = 0; n < 16; n++) begin
      x = {$urandom, $urandom, $urandom, $urandom};
      sw_in = x;
      #1;
      y = dswap_model(x);
      check(sw_out == y, "R3 double swap random", sw_out, y);
    end

    // R7 stalls exercised by partial ready rates
    run_stream(128'h0, {128{1'b1}}, 100, 1'b0);
    run_stream({128{1'b1}}, 128'h0, 100, 1'b0);
    for (int r = 0; r < 4; r++) begin
      run_stream({$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, (r == 0) ? 50 : 30 + 15*r, 1'b0);
    end
    run_stream({$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, 40, 1'b1);
    run_stream(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
               128'h8000_0000_0000_0000_0000_0000_0000_0001, 20, 1'b1);

    summary();
    $finish;
  end
endmodule